// File: doc/BRIEF.md
# Reject-and-Retry Request Acceptance Port

This block controls whether requests from an upstream requester are taken in. It does not stall the requester. While the port cannot take work, it turns each arriving request away and records that a retry is owed. The owning logic raises and lowers a set of independent block causes, one bit each. The port counts as blocked while any cause is set.

When the last cause clears and a retry is owed, the port schedules a single retry strobe for the cycle after the unblock. The requester resends its request on that strobe. If a cause is set again before the strobe goes out, the scheduled strobe is dropped and the debt stays open until the next unblock. The block only handles this flow control. Packet contents and whatever sits behind the port belong to other logic.

Top module: `retry_port_ctrl`

## Requirements
- R1: After synchronous reset, `blocked_o` is 0, `req_accept_o` is 1 and `retry_o` is 0.
- R2: While `blocked_o` is 1, `req_accept_o` is 0. A request (`req_valid_i`=1) seen then is refused and records an owed retry. The owed retry keeps `req_accept_o` at 0 after the unblock until the retry is issued.
- R3: With no cause set and no retry owed, `req_accept_o` is 1 and a request is taken. Taking a request leaves the port able to take the next one.
- R4: A cause vector is cleared at edge k and leaves no cause set, with a retry owed. Then `retry_o` is 1 for exactly the cycle that follows edge k+1.
- R5: If any cause is set at edge k+1 (the edge at which the scheduled retry would fire), the retry is cancelled, `retry_o` stays 0 and the retry remains owed.
- R6: Issuing the retry clears the owed flag, so `req_accept_o` is 1 in the cycle where `retry_o` is 1.
- R7: Cause bit i is set by `cause_set_i[i]` and cleared by `cause_clr_i[i]`. `blocked_o` is 1 while any bit is set and falls only when the last bit clears.
- R8: Setting a cause that is already set, or clearing one already clear, leaves `blocked_o`, `req_accept_o` and `retry_o` unchanged.
- R9: One unblock yields at most one retry pulse, whatever the number of refused requests.
- R10: An unblock with no refused request during the blocked interval produces no retry.
- R11: When `cause_set_i[i]` and `cause_clr_i[i]` are both 1 in one cycle, the set wins and bit i ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Requester presents a request this cycle |
| req_accept_o | output | 1 | Request is taken this cycle (0 means refused) |
| cause_set_i | input | NUM_CAUSES | Per-cause set strobes |
| cause_clr_i | input | NUM_CAUSES | Per-cause clear strobes |
| blocked_o | output | 1 | At least one block cause is active |
| retry_o | output | 1 | One-cycle retry strobe toward the requester |

## Verification
The bench builds the port with its default of four causes. With four causes it can hold two causes at once and clear them one at a time, which tests R7's rule that the last cause to clear ends the block. It also covers redundant strobes on a bit that is already set or already clear, and a simultaneous set and clear on one bit. Directed sequences place a refused request, an unblock and a fresh block cause at fixed edges. These sequences test the one-cycle deferral, the cancellation window and the one-pulse rule.

// File: rtl/retry_port_pkg.sv
package retry_port_pkg;

    localparam int DEF_CAUSES = 4;

    typedef enum logic [1:0] {
        REQ_IDLE    = 2'd0,
        REQ_TAKEN   = 2'd1,
        REQ_REFUSED = 2'd2
    } req_outcome_e;

    typedef struct packed {
        logic owed;
        logic sched;
        logic strobe;
    } retry_state_t;

    function automatic req_outcome_e classify(input logic valid, input logic open_gate);
        if (!valid)
            return REQ_IDLE;
        else if (open_gate)
            return REQ_TAKEN;
        else
            return REQ_REFUSED;
    endfunction

    function automatic logic next_owed(input req_outcome_e outc, input logic fire, input logic owed);
        if (fire)
            return 1'b0;
        case (outc)
            REQ_REFUSED: return 1'b1;
            REQ_TAKEN:   return 1'b0;
            default:     return owed;
        endcase
    endfunction

endpackage

// File: rtl/rpc_cause_vec.sv
module rpc_cause_vec #(
    parameter int NUM_CAUSES = retry_port_pkg::DEF_CAUSES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CAUSES-1:0] set_i,
    input  logic [NUM_CAUSES-1:0] clr_i,
    output logic                  blocked_o,
    output logic                  block_next_o,
    output logic                  unblock_o
);
    logic [NUM_CAUSES-1:0] cause_q;
    logic [NUM_CAUSES-1:0] cause_d;

    for (genvar gi = 0; gi < NUM_CAUSES; gi++) begin : g_bit
        always_comb begin
            if (set_i[gi])
                cause_d[gi] = 1'b1;
            else if (clr_i[gi])
                cause_d[gi] = 1'b0;
            else
                cause_d[gi] = cause_q[gi];
        end

        always_ff @(posedge clk) begin
            if (rst)
                cause_q[gi] <= 1'b0;
            else
                cause_q[gi] <= cause_d[gi];
        end
    end

    assign blocked_o    = |cause_q;
    assign block_next_o = |cause_d;
    assign unblock_o    = blocked_o && !block_next_o;
endmodule

// File: rtl/rpc_accept_gate.sv
module rpc_accept_gate
    import retry_port_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic blocked_i,
    input  logic valid_i,
    input  logic fire_i,
    output logic accept_o,
    output logic owed_next_o
);
    logic         owed_q;
    req_outcome_e outc;

    assign accept_o    = !blocked_i && !owed_q;
    assign outc        = classify(valid_i, accept_o);
    assign owed_next_o = next_owed(outc, fire_i, owed_q);

    always_ff @(posedge clk) begin
        if (rst)
            owed_q <= 1'b0;
        else
            owed_q <= owed_next_o;
    end
endmodule

// File: rtl/rpc_retry_sched.sv
module rpc_retry_sched
    import retry_port_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic unblock_i,
    input  logic owed_next_i,
    input  logic block_next_i,
    output logic fire_o,
    output logic retry_o
);
    retry_state_t st_q;
    retry_state_t st_d;

    assign fire_o = st_q.sched && !block_next_i;

    always_comb begin
        st_d        = st_q;
        st_d.owed   = owed_next_i;
        st_d.sched  = unblock_i && owed_next_i;
        st_d.strobe = fire_o;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign retry_o = st_q.strobe;
endmodule

// File: rtl/retry_port_ctrl.sv
module retry_port_ctrl #(
    parameter int NUM_CAUSES = retry_port_pkg::DEF_CAUSES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid_i,
    output logic                  req_accept_o,
    input  logic [NUM_CAUSES-1:0] cause_set_i,
    input  logic [NUM_CAUSES-1:0] cause_clr_i,
    output logic                  blocked_o,
    output logic                  retry_o
);
    logic block_next;
    logic unblock;
    logic fire;
    logic owed_next;

    rpc_cause_vec #(.NUM_CAUSES(NUM_CAUSES)) u_causes (
        .clk          (clk),
        .rst          (rst),
        .set_i        (cause_set_i),
        .clr_i        (cause_clr_i),
        .blocked_o    (blocked_o),
        .block_next_o (block_next),
        .unblock_o    (unblock)
    );

    rpc_accept_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .blocked_i   (blocked_o),
        .valid_i     (req_valid_i),
        .fire_i      (fire),
        .accept_o    (req_accept_o),
        .owed_next_o (owed_next)
    );

    rpc_retry_sched u_sched (
        .clk          (clk),
        .rst          (rst),
        .unblock_i    (unblock),
        .owed_next_i  (owed_next),
        .block_next_i (block_next),
        .fire_o       (fire),
        .retry_o      (retry_o)
    );
endmodule

// File: rtl/retry_port_chk.sv
module retry_port_chk (
    input logic clk,
    input logic rst,
    input logic req_accept_o,
    input logic blocked_o,
    input logic retry_o
);
    AST_BLOCKED_REFUSES: assert property (@(posedge clk) disable iff (rst)
        blocked_o |-> !req_accept_o); // R2

    AST_RETRY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        retry_o |=> !retry_o); // R9

    AST_RETRY_UNBLOCKED: assert property (@(posedge clk) disable iff (rst)
        retry_o |-> !blocked_o); // R5

    AST_RETRY_OPENS: assert property (@(posedge clk) disable iff (rst)
        retry_o |-> req_accept_o); // R6

    AST_RETRY_DEFERRED: assert property (@(posedge clk) disable iff (rst)
        $rose(retry_o) |-> (!$past(blocked_o) && $past(blocked_o, 2))); // R4
endmodule

bind retry_port_ctrl retry_port_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_accept_o (req_accept_o),
    .blocked_o    (blocked_o),
    .retry_o      (retry_o)
);

// File: tb/test_retry_port_ctrl.sv
module test_retry_port_ctrl;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid_i = 1'b0;
    logic          req_accept_o;
    logic [NC-1:0] cause_set_i = '0;
    logic [NC-1:0] cause_clr_i = '0;
    logic          blocked_o;
    logic          retry_o;

    int n_chk = 0;
    int n_bad = 0;
    int retry_seen;

    always #5 clk = ~clk;

    retry_port_ctrl #(.NUM_CAUSES(NC)) i_retry_port_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid_i  (req_valid_i),
        .req_accept_o (req_accept_o),
        .cause_set_i  (cause_set_i),
        .cause_clr_i  (cause_clr_i),
        .blocked_o    (blocked_o),
        .retry_o      (retry_o)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic expect_state(input logic b, input logic a, input logic r, input string tag);
        check(blocked_o, b, {tag, " blocked_o"});
        check(req_accept_o, a, {tag, " req_accept_o"});
        check(retry_o, r, {tag, " retry_o"});
    endtask

    task automatic pulse_set(input int bitn);
        cause_set_i = '0;
        cause_set_i[bitn] = 1'b1;
        cyc();
        cause_set_i = '0;
    endtask

    task automatic pulse_clr(input int bitn);
        cause_clr_i = '0;
        cause_clr_i[bitn] = 1'b1;
        cyc();
        cause_clr_i = '0;
    endtask

    task automatic test_reset();
        rst = 1'b1;
        cyc(); cyc();
        rst = 1'b0;
        expect_state(1'b0, 1'b1, 1'b0, "R1 reset");
    endtask

    task automatic test_accept();
        req_valid_i = 1'b1;
        check(req_accept_o, 1'b1, "R3 first request taken");
        cyc();
        check(req_accept_o, 1'b1, "R3 next request taken");
        req_valid_i = 1'b0;
        cyc();
        expect_state(1'b0, 1'b1, 1'b0, "R3 idle");
    endtask

    task automatic test_block_retry();
        pulse_set(0);
        expect_state(1'b1, 1'b0, 1'b0, "R7 set bit0");
        req_valid_i = 1'b1;
        check(req_accept_o, 1'b0, "R2 refused while blocked");
        cyc();
        req_valid_i = 1'b0;
        pulse_clr(0);
        expect_state(1'b0, 1'b0, 1'b0, "R2 owed keeps refusing after unblock");
        cyc();
        expect_state(1'b0, 1'b1, 1'b1, "R4 retry one cycle after unblock / R6");
        cyc();
        expect_state(1'b0, 1'b1, 1'b0, "R4 retry lasts one cycle");
    endtask

    task automatic test_cancel();
        pulse_set(2);
        req_valid_i = 1'b1;
        cyc();
        req_valid_i = 1'b0;
        pulse_clr(2);
        expect_state(1'b0, 1'b0, 1'b0, "R5 unblocked with retry scheduled");
        pulse_set(1);
        expect_state(1'b1, 1'b0, 1'b0, "R5 retry cancelled by new block");
        cyc();
        check(retry_o, 1'b0, "R5 no late retry");
        pulse_clr(1);
        check(retry_o, 1'b0, "R5 no retry at unblock edge");
        cyc();
        expect_state(1'b0, 1'b1, 1'b1, "R5 owed retry issued on later unblock");
        cyc();
    endtask

    task automatic test_multi_cause();
        cause_set_i = 4'b1001;
        cyc();
        cause_set_i = '0;
        req_valid_i = 1'b1;
        cyc(); cyc(); cyc();
        req_valid_i = 1'b0;
        pulse_clr(0);
        expect_state(1'b1, 1'b0, 1'b0, "R7 still blocked with one cause left");
        pulse_clr(3);
        check(blocked_o, 1'b0, "R7 last cause clears block");
        retry_seen = 0;
        for (int i = 0; i < 6; i++) begin
            cyc();
            if (retry_o) retry_seen++;
        end
        check(retry_seen == 1, 1'b1, "R9 one pulse for several refusals");
    endtask

    task automatic test_redundant();
        pulse_clr(2);
        expect_state(1'b0, 1'b1, 1'b0, "R8 clear of clear bit");
        pulse_set(3);
        pulse_set(3);
        expect_state(1'b1, 1'b0, 1'b0, "R8 set of set bit");
        pulse_clr(3);
        expect_state(1'b0, 1'b1, 1'b0, "R10 unblock with nothing refused");
        cyc();
        check(retry_o, 1'b0, "R10 no retry without refusal");
    endtask

    task automatic test_set_wins();
        cause_set_i = 4'b0100;
        cause_clr_i = 4'b0100;
        cyc();
        cause_set_i = '0;
        cause_clr_i = '0;
        check(blocked_o, 1'b1, "R11 set wins over clear");
        pulse_clr(2);
        check(blocked_o, 1'b0, "R11 later clear works");
        cyc();
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        test_reset();
        test_accept();
        test_block_retry();
        test_cancel();
        test_multi_cause();
        test_redundant();
        test_set_wins();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule